// File: doc/BRIEF.md
# Banked Data Memory Address Generator

This block produces the 12-bit data memory address for an 8-bit microcontroller core whose register file is 4 KB. The address comes from one of two sources. The first is the 8-bit file field of a decoded instruction. The second is one of three 16-bit pointer registers, used when the core asks for indirect access.

A per-instruction select bit decides how a direct file field is widened to 12 bits. The field can be placed inside the bank named by a 4-bit bank register. It can instead go through a split shared window. In that window the lower half of the field lands at the bottom of bank 0, and the upper half lands in the special function register area at the top of the space.

The block keeps the bank register and the three pointers, and the core loads them through strobes. Each output address comes with a flag that tells special function registers apart from general purpose RAM.

Top module: `dmem_addr_gen`

## Requirements
- R1: Reset clears the bank register and all three pointers to zero. After reset, a banked direct access gives `{4'h0, fileAddr}` and an indirect access through any pointer gives 0x000.
- R2: Direct access with `bankedSel`=0 and `fileAddr` in 0x00..0x7F gives `effAddr` = 0x000 + `fileAddr`.
- R3: Direct access with `bankedSel`=0 and `fileAddr` in 0x80..0xFF gives `effAddr` = 0xF00 + `fileAddr`, which is 0xF80..0xFFF.
- R4: Direct access with `bankedSel`=1 gives `effAddr` = `{bank register, fileAddr}`. For example, bank 2 with file 0x00 gives 0x200.
- R5: `bankLoad` writes `bankData` into the bank register. The new value is used from the next cycle on. The cycle in which the strobe is high still uses the old value.
- R6: `ptrLoad` writes `ptrData` into the pointer chosen by `ptrWrSel` (0, 1 or 2). From the next cycle on, `indirect`=1 with `indSel` naming that pointer gives the pointer's bits 11..0 as `effAddr`. A write leaves the other pointers unchanged.
- R7: A pointer write with `ptrWrSel`=3 changes no pointer. An indirect access with `indSel`=3 gives 0x000.
- R8: When `indirect`=1, `fileAddr` and `bankedSel` have no effect on `effAddr`.
- R9: `isSfr` is 1 exactly when `effAddr` bits 11..7 are all ones (0xF80..0xFFF). Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fileAddr | input | 8 | File address field of the instruction |
| bankedSel | input | 1 | 0: shared split window, 1: bank register |
| bankLoad | input | 1 | Write strobe for the bank register |
| bankData | input | 4 | New bank register value |
| ptrLoad | input | 1 | Write strobe for a pointer |
| ptrWrSel | input | 2 | Pointer written by ptrLoad |
| ptrData | input | 16 | New pointer value |
| indirect | input | 1 | Take the address from a pointer |
| indSel | input | 2 | Pointer read in indirect mode |
| effAddr | output | 12 | Effective data address |
| isSfr | output | 1 | Address is in the special function area |

## Verification
The hardest cases to reach are the ones where a strobe and an address use land in the same cycle. A bank load at the same moment as a banked access must still show the old bank. A pointer write must show up in the very next indirect read, while the other pointers keep their values. The stimulus sets up these collisions on purpose, including the out-of-range pointer index for both write and read. A long random phase then mixes every strobe with every address mode and compares each cycle against a behavioural model.

// File: rtl/dag_pkg.sv
package dag_pkg;
  localparam int ADDR_W  = 12;
  localparam int FILE_W  = 8;
  localparam int BANK_W  = ADDR_W - FILE_W;
  localparam int PTR_W   = 16;
  localparam int NUM_PTR = 3;
  localparam int IDX_W   = $clog2(NUM_PTR + 1);
  localparam int SFR_W   = ADDR_W - FILE_W + 1;

  typedef struct packed {
    logic               bankWe;
    logic [NUM_PTR-1:0] ptrWe;
    logic               useInd;
    logic               useBank;
    logic [IDX_W-1:0]   rdIdx;
    logic               rdValid;
  } dagStrobes_t;
endpackage

// File: rtl/dag_ctrl.sv
module dag_ctrl
  import dag_pkg::*;
(
  input  logic             bankLoad,
  input  logic             ptrLoad,
  input  logic [IDX_W-1:0] ptrWrSel,
  input  logic             indirect,
  input  logic [IDX_W-1:0] indSel,
  input  logic             bankedSel,
  output dagStrobes_t      strb
);
  logic [NUM_PTR-1:0] wrDec;

  // one write enable per pointer; an out-of-range index enables none
  for (genvar g = 0; g < NUM_PTR; g++) begin : g_wrDec
    assign wrDec[g] = ptrLoad && (ptrWrSel == IDX_W'(g));
  end

  always_comb begin
    strb.bankWe  = bankLoad;
    strb.ptrWe   = wrDec;
    strb.useInd  = indirect;
    strb.useBank = bankedSel;
    strb.rdIdx   = indSel;
    strb.rdValid = (int'(indSel) < NUM_PTR);
  end
endmodule

// File: rtl/dag_datapath.sv
module dag_datapath
  import dag_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dagStrobes_t       strb,
  input  logic [FILE_W-1:0] fileAddr,
  input  logic [BANK_W-1:0] bankData,
  input  logic [PTR_W-1:0]  ptrData,
  output logic [ADDR_W-1:0] effAddr,
  output logic              isSfr
);
  logic [BANK_W-1:0] bankReg;
  logic [PTR_W-1:0]  ptrReg [NUM_PTR];
  logic [PTR_W-1:0]  selPtr;
  logic [ADDR_W-1:0] directAddr;

  always_ff @(posedge clk) begin
    if (!rstN)            bankReg <= '0;
    else if (strb.bankWe) bankReg <= bankData;
  end

  for (genvar g = 0; g < NUM_PTR; g++) begin : g_ptr
    always_ff @(posedge clk) begin
      if (!rstN)              ptrReg[g] <= '0;
      else if (strb.ptrWe[g]) ptrReg[g] <= ptrData;
    end
  end

  always_comb begin
    selPtr = '0;
    for (int i = 0; i < NUM_PTR; i++)
      if (strb.rdValid && strb.rdIdx == IDX_W'(i)) selPtr = ptrReg[i];
  end

  // shared window: the top bit of the field picks bottom or top of the space
  always_comb begin
    if (strb.useBank) directAddr = {bankReg, fileAddr};
    else              directAddr = {{BANK_W{fileAddr[FILE_W-1]}}, fileAddr};
  end

  assign effAddr = strb.useInd ? selPtr[ADDR_W-1:0] : directAddr;
  assign isSfr   = &effAddr[ADDR_W-1:ADDR_W-SFR_W];
endmodule

// File: rtl/dmem_addr_gen.sv
module dmem_addr_gen
  import dag_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [7:0]  fileAddr,
  input  logic        bankedSel,
  input  logic        bankLoad,
  input  logic [3:0]  bankData,
  input  logic        ptrLoad,
  input  logic [1:0]  ptrWrSel,
  input  logic [15:0] ptrData,
  input  logic        indirect,
  input  logic [1:0]  indSel,
  output logic [11:0] effAddr,
  output logic        isSfr
);
  dagStrobes_t strb;

  dag_ctrl u_ctrl (
    .bankLoad (bankLoad),
    .ptrLoad  (ptrLoad),
    .ptrWrSel (ptrWrSel),
    .indirect (indirect),
    .indSel   (indSel),
    .bankedSel(bankedSel),
    .strb     (strb)
  );

  dag_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .fileAddr(fileAddr),
    .bankData(bankData),
    .ptrData (ptrData),
    .effAddr (effAddr),
    .isSfr   (isSfr)
  );
endmodule

// File: rtl/dmem_addr_gen_checker.sv
module dmem_addr_gen_checker (
  input logic        clk,
  input logic        rstN,
  input logic [7:0]  fileAddr,
  input logic        bankedSel,
  input logic        bankLoad,
  input logic [3:0]  bankData,
  input logic        ptrLoad,
  input logic [1:0]  ptrWrSel,
  input logic [15:0] ptrData,
  input logic        indirect,
  input logic [1:0]  indSel,
  input logic [11:0] effAddr,
  input logic        isSfr
);
  p_access_low_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!indirect && !bankedSel && !fileAddr[7]) |-> effAddr == {4'h0, fileAddr});

  p_access_high_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!indirect && !bankedSel && fileAddr[7]) |-> effAddr == {4'hF, fileAddr});

  p_bank_next_r5: assert property (@(posedge clk) disable iff (!rstN)
    bankLoad ##1 (!indirect && bankedSel) |-> effAddr[11:8] == $past(bankData));

  p_ptr_next_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ptrLoad && ptrWrSel != 2'd3) ##1 (indirect && indSel == $past(ptrWrSel))
      |-> effAddr == $past(ptrData[11:0]));

  p_idx3_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    (indirect && indSel == 2'd3) |-> effAddr == 12'h000);

  p_sfr_flag_r9: assert property (@(posedge clk) disable iff (!rstN)
    isSfr == (effAddr >= 12'hF80));
endmodule

bind dmem_addr_gen dmem_addr_gen_checker u_chk (.*);

// File: tb/tb_dmem_addr_gen.sv
`timescale 1ns/1ps
module tb_dmem_addr_gen;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  fileAddr = '0;
  logic        bankedSel = 1'b0;
  logic        bankLoad = 1'b0;
  logic [3:0]  bankData = '0;
  logic        ptrLoad = 1'b0;
  logic [1:0]  ptrWrSel = '0;
  logic [15:0] ptrData = '0;
  logic        indirect = 1'b0;
  logic [1:0]  indSel = '0;
  logic [11:0] effAddr;
  logic        isSfr;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;
  string tagOv = "";

  // behavioural model state
  int mBank;
  int mPtr [3];

  always #2.5 clk = ~clk;

  dmem_addr_gen dut (.*);

  function automatic int expAddr();
    if (indirect) return (indSel == 2'd3) ? 0 : (mPtr[indSel] & 'hFFF);
    if (bankedSel) return mBank * 256 + int'(fileAddr);
    if (fileAddr < 8'h80) return int'(fileAddr);
    return 'hF00 + int'(fileAddr);
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // inputs already set after a negedge; compare, then advance one edge
  task automatic step();
    string tag;
    int e;
    #1;
    e = expAddr();
    if (tagOv != "") tag = tagOv;
    else if (indirect) tag = (indSel == 2'd3) ? "R7" : "R6";
    else if (bankedSel) tag = "R4";
    else tag = fileAddr[7] ? "R3" : "R2";
    chk(tag, int'(effAddr), e);
    chk("R9", int'(isSfr), (e >= 'hF80) ? 1 : 0);
    @(posedge clk);
    if (rstN) begin
      if (bankLoad) mBank = int'(bankData);
      if (ptrLoad && ptrWrSel != 2'd3) mPtr[ptrWrSel] = int'(ptrData);
    end
    @(negedge clk);
    bankLoad = 0; ptrLoad = 0; tagOv = "";
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin : watchdog
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        checks++; fails++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
      end
    end
  end

  initial begin
    mBank = 0;
    for (int i = 0; i < 3; i++) mPtr[i] = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1: reset state seen through ports
    bankedSel = 1; fileAddr = 8'h34; tagOv = "R1"; step();
    for (int i = 0; i < 3; i++) begin
      indirect = 1; indSel = 2'(i); tagOv = "R1"; step();
    end
    indirect = 0;
    // R2/R3: shared window sweep
    bankedSel = 0;
    for (int f = 0; f < 256; f += 17) begin fileAddr = 8'(f); step(); end
    fileAddr = 8'h7F; step();
    fileAddr = 8'h80; step();
    // R5: load bank 2 while in use; old value this cycle, new next cycle
    bankedSel = 1; fileAddr = 8'h00; bankLoad = 1; bankData = 4'h2; tagOv = "R5"; step();
    tagOv = "R5"; step();
    // R4/R9 boundary in bank 15
    bankLoad = 1; bankData = 4'hF; step();
    fileAddr = 8'h7F; step();
    fileAddr = 8'h80; step();
    // R6: pointer loads, each read next cycle
    ptrLoad = 1; ptrWrSel = 0; ptrData = 16'hABCD; step();
    ptrLoad = 1; ptrWrSel = 1; ptrData = 16'h1F80; indirect = 1; indSel = 0; step();
    ptrLoad = 1; ptrWrSel = 2; ptrData = 16'h0123; indSel = 1; step();
    // R7: write with index 3 must not disturb anything
    ptrLoad = 1; ptrWrSel = 3; ptrData = 16'hFFFF; indSel = 2; step();
    for (int i = 0; i < 4; i++) begin indSel = 2'(i); step(); end
    // R8: indirect ignores file field and select bit
    indSel = 1;
    for (int f = 0; f < 4; f++) begin
      fileAddr = 8'(f * 61); bankedSel = f[0]; tagOv = "R8"; step();
    end
    // random mix of every mode and strobe
    for (int n = 0; n < 400; n++) begin
      fileAddr = 8'($urandom); bankedSel = 1'($urandom);
      bankLoad = 1'($urandom); bankData = 4'($urandom);
      ptrLoad = 1'($urandom); ptrWrSel = 2'($urandom); ptrData = 16'($urandom);
      indirect = 1'($urandom); indSel = 2'($urandom);
      step();
    end
    done = 1;
    summary();
  end
endmodule